// File: doc/BRIEF.md
# Windowed Integer Register File

This block holds the integer registers of a core whose register set slides over a ring of overlapping windows. Each instruction names one of 32 logical registers. A current window pointer (CWP) and the register number together select one physical entry. Eight global registers are common to every window. Each window owns eight private locals. Its eight outgoing registers are the same storage as the eight incoming registers of the window one step below it in the ring. As a result, a caller's outgoing values become the callee's incoming values without any data being copied.

The block has two read ports with registered data and one write port. A save moves the pointer one window down and a restore moves it one window up, both modulo the window count. A window invalid mask (WIM) marks windows that cannot be entered. A save or restore that would land on a marked window leaves the pointer in place and raises a one-cycle overflow or underflow flag, which the surrounding core turns into a trap. A trap-entry request always moves the pointer down without consulting the mask. Software can load the pointer and the mask directly and observe both at any time.

Top module: `winreg_file`

## Requirements
- R1: While reset is held, and on the first cycle after it, `cwp_o` is 0, `wim_o` is 0, both flags are 0 and both read data outputs are 0.
- R2: Logical register 0 reads as zero on both ports. A write to register 0 changes nothing.
- R3: Logical registers 1 to 7 are globals. A value written to one of them in any window reads back unchanged in every window.
- R4: Read data appears on the clock edge after the address is presented. If a write to the same register occurs in the same cycle, the read returns the previous contents, and the new value is returned from the following cycle.
- R5: Logical registers 16 to 23 are locals. Each window has its own eight locals, and a write in one window does not change the locals of any other window.
- R6: Logical register 8+k (k = 0..7) in window w is the same storage as logical register 24+k in window (w-1) mod NWIN. Writing through either name is visible through the other.
- R7: A save decrements the CWP modulo NWIN, and a restore increments it modulo NWIN, when the WIM bit of the target window is 0.
- R8: A save whose target window has its WIM bit at 1 leaves the CWP unchanged and drives `ovf_flag` high for exactly the next cycle. A restore whose target is marked drives `unf_flag` in the same way. The two flags are never high together.
- R9: A trap entry decrements the CWP modulo NWIN whatever the WIM holds, and it raises no flag.
- R10: `ctl_wr_cwp` loads the CWP from the low log2(NWIN) bits of `ctl_wdata`, and `ctl_wr_wim` loads the WIM from all NWIN bits of it (bit i marks window i). Both new values appear on `cwp_o` and `wim_o` after the clock edge.
- R11: When several pointer requests come in the same cycle, only one takes effect, in this priority order: software pointer load, then trap entry, then save, then restore.
- R12: NWIN is a power of two from 2 to 32, with a default of 8.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rd_a_addr | input | 5 | Logical register for read port A |
| rd_b_addr | input | 5 | Logical register for read port B |
| rd_a_data | output | XLEN | Registered read data, port A |
| rd_b_data | output | XLEN | Registered read data, port B |
| wr_en | input | 1 | Write strobe |
| wr_addr | input | 5 | Logical register to write |
| wr_data | input | XLEN | Write data |
| save_req | input | 1 | Move to the next lower window, checked against the WIM |
| restore_req | input | 1 | Move to the next higher window, checked against the WIM |
| trap_enter | input | 1 | Move to the next lower window with no check |
| ctl_wr_cwp | input | 1 | Load the CWP from `ctl_wdata` |
| ctl_wr_wim | input | 1 | Load the WIM from `ctl_wdata` |
| ctl_wdata | input | NWIN | Data for the pointer and mask loads |
| cwp_o | output | log2(NWIN) | Current window pointer |
| wim_o | output | NWIN | Window invalid mask |
| ovf_flag | output | 1 | One-cycle pulse: a save was refused |
| unf_flag | output | 1 | One-cycle pulse: a restore was refused |

## Verification
Each pointer-step property is gated by the requests that outrank it. The properties therefore need no promise that the requests arrive one at a time, and the bench deliberately issues overlapping requests to exercise the priority order. The zero-register properties assume that the read address is held stable across the edge at which it is sampled. The bench drives every input a fixed delay after the rising edge, so each address is stable at the edge where it is sampled. Memory contents are not reset, so the bench writes every register before it reads it, and it compares those reads only against values it has written itself.

// File: rtl/winreg_pkg.sv
package winreg_pkg;
  // Register group is taken from the top two bits of the logical number.
  typedef enum logic [1:0] {
    GRP_GLB = 2'd0,
    GRP_OUT = 2'd1,
    GRP_LOC = 2'd2,
    GRP_IN  = 2'd3
  } reg_grp_e;

  localparam int LADDR_W = 5;

  function automatic reg_grp_e grp_of(input logic [LADDR_W-1:0] a);
    return reg_grp_e'(a[4:3]);
  endfunction
endpackage

// File: rtl/winreg_map.sv
module winreg_map
  import winreg_pkg::*;
#(
  parameter int NWIN = 8
) (
  input  logic [$clog2(NWIN)-1:0]    cwp,
  input  logic [LADDR_W-1:0]         laddr,
  output logic                       is_glb,
  output logic [2:0]                 gidx,
  output logic [$clog2(NWIN*16)-1:0] pidx
);
  localparam int CWPW = $clog2(NWIN);

  logic [CWPW-1:0] cwp_up;
  assign cwp_up = cwp + CWPW'(1);

  always_comb begin
    is_glb = 1'b0;
    gidx   = laddr[2:0];
    pidx   = '0;
    unique case (grp_of(laddr))
      GRP_GLB: is_glb = 1'b1;
      GRP_OUT: pidx = {cwp,    1'b0, laddr[2:0]};
      GRP_LOC: pidx = {cwp,    1'b1, laddr[2:0]};
      GRP_IN:  pidx = {cwp_up, 1'b0, laddr[2:0]};
      default: pidx = '0;
    endcase
  end
endmodule

// File: rtl/winreg_bank.sv
module winreg_bank #(
  parameter int NWIN = 8,
  parameter int XLEN = 32,
  parameter int NRD  = 2
) (
  input  logic                                  clk,
  input  logic                                  rst,
  input  logic                                  we,
  input  logic                                  w_glb,
  input  logic [2:0]                            w_gidx,
  input  logic [$clog2(NWIN*16)-1:0]            w_pidx,
  input  logic [XLEN-1:0]                       wdata,
  input  logic [NRD-1:0]                        r_glb,
  input  logic [NRD-1:0][2:0]                   r_gidx,
  input  logic [NRD-1:0][$clog2(NWIN*16)-1:0]   r_pidx,
  output logic [NRD-1:0][XLEN-1:0]              r_data
);
  localparam int WENT = NWIN * 16;

  logic [XLEN-1:0] win_mem [WENT];
  logic [XLEN-1:0] glb_mem [8];

  always_ff @(posedge clk) begin
    if (we) begin
      if (!w_glb)              win_mem[w_pidx] <= wdata;
      else if (w_gidx != 3'd0) glb_mem[w_gidx] <= wdata;
    end
  end

  for (genvar p = 0; p < NRD; p++) begin : g_rport
    logic [XLEN-1:0] q;
    always_ff @(posedge clk) begin
      if (rst)                              q <= '0;
      else if (r_glb[p] && r_gidx[p] == 3'd0) q <= '0;
      else if (r_glb[p])                    q <= glb_mem[r_gidx[p]];
      else                                  q <= win_mem[r_pidx[p]];
    end
    assign r_data[p] = q;
  end
endmodule

// File: rtl/winreg_ptr.sv
module winreg_ptr #(
  parameter int NWIN = 8
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    save_req,
  input  logic                    restore_req,
  input  logic                    trap_enter,
  input  logic                    ctl_wr_cwp,
  input  logic                    ctl_wr_wim,
  input  logic [NWIN-1:0]         ctl_wdata,
  output logic [$clog2(NWIN)-1:0] cwp,
  output logic [NWIN-1:0]         wim,
  output logic                    ovf,
  output logic                    unf
);
  localparam int CWPW = $clog2(NWIN);

  logic [CWPW-1:0] cwp_dn, cwp_up;
  assign cwp_dn = cwp - CWPW'(1);
  assign cwp_up = cwp + CWPW'(1);

  always_ff @(posedge clk) begin
    if (rst) begin
      cwp <= '0;
      ovf <= 1'b0;
      unf <= 1'b0;
    end else begin
      ovf <= 1'b0;
      unf <= 1'b0;
      if (ctl_wr_cwp)      cwp <= ctl_wdata[CWPW-1:0];
      else if (trap_enter) cwp <= cwp_dn;
      else if (save_req) begin
        if (wim[cwp_dn]) ovf <= 1'b1;
        else             cwp <= cwp_dn;
      end else if (restore_req) begin
        if (wim[cwp_up]) unf <= 1'b1;
        else             cwp <= cwp_up;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst)             wim <= '0;
    else if (ctl_wr_wim) wim <= ctl_wdata;
  end
endmodule

// File: rtl/winreg_file.sv
module winreg_file #(
  parameter int NWIN = 8,
  parameter int XLEN = 32
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic [4:0]              rd_a_addr,
  input  logic [4:0]              rd_b_addr,
  output logic [XLEN-1:0]         rd_a_data,
  output logic [XLEN-1:0]         rd_b_data,
  input  logic                    wr_en,
  input  logic [4:0]              wr_addr,
  input  logic [XLEN-1:0]         wr_data,
  input  logic                    save_req,
  input  logic                    restore_req,
  input  logic                    trap_enter,
  input  logic                    ctl_wr_cwp,
  input  logic                    ctl_wr_wim,
  input  logic [NWIN-1:0]         ctl_wdata,
  output logic [$clog2(NWIN)-1:0] cwp_o,
  output logic [NWIN-1:0]         wim_o,
  output logic                    ovf_flag,
  output logic                    unf_flag
);
  localparam int CWPW = $clog2(NWIN);
  localparam int PIW  = $clog2(NWIN * 16);
  localparam int NRD  = 2;

  // R12: window count must be a power of two in 2..32
  if (NWIN < 2 || NWIN > 32 || (NWIN & (NWIN - 1)) != 0) begin : g_bad_nwin
    $error("winreg_file: NWIN must be a power of two from 2 to 32");
  end

  logic [CWPW-1:0] cwp;

  logic [NRD-1:0]           r_glb;
  logic [NRD-1:0][2:0]      r_gidx;
  logic [NRD-1:0][PIW-1:0]  r_pidx;
  logic [NRD-1:0][XLEN-1:0] r_data;
  logic [NRD-1:0][4:0]      r_addr;
  logic                     w_glb;
  logic [2:0]               w_gidx;
  logic [PIW-1:0]           w_pidx;

  assign r_addr[0] = rd_a_addr;
  assign r_addr[1] = rd_b_addr;

  for (genvar p = 0; p < NRD; p++) begin : g_rmap
    winreg_map #(.NWIN(NWIN)) u_map (
      .cwp(cwp), .laddr(r_addr[p]),
      .is_glb(r_glb[p]), .gidx(r_gidx[p]), .pidx(r_pidx[p])
    );
  end

  winreg_map #(.NWIN(NWIN)) u_wmap (
    .cwp(cwp), .laddr(wr_addr),
    .is_glb(w_glb), .gidx(w_gidx), .pidx(w_pidx)
  );

  winreg_bank #(.NWIN(NWIN), .XLEN(XLEN), .NRD(NRD)) u_bank (
    .clk(clk), .rst(rst),
    .we(wr_en), .w_glb(w_glb), .w_gidx(w_gidx), .w_pidx(w_pidx), .wdata(wr_data),
    .r_glb(r_glb), .r_gidx(r_gidx), .r_pidx(r_pidx), .r_data(r_data)
  );

  winreg_ptr #(.NWIN(NWIN)) u_ptr (
    .clk(clk), .rst(rst),
    .save_req(save_req), .restore_req(restore_req), .trap_enter(trap_enter),
    .ctl_wr_cwp(ctl_wr_cwp), .ctl_wr_wim(ctl_wr_wim), .ctl_wdata(ctl_wdata),
    .cwp(cwp), .wim(wim_o), .ovf(ovf_flag), .unf(unf_flag)
  );

  assign cwp_o     = cwp;
  assign rd_a_data = r_data[0];
  assign rd_b_data = r_data[1];
endmodule

// File: rtl/winreg_file_chk.sv
module winreg_file_chk #(
  parameter int NWIN = 8,
  parameter int XLEN = 32
) (
  input logic                    clk,
  input logic                    rst,
  input logic [4:0]              rd_a_addr,
  input logic [4:0]              rd_b_addr,
  input logic [XLEN-1:0]         rd_a_data,
  input logic [XLEN-1:0]         rd_b_data,
  input logic                    save_req,
  input logic                    restore_req,
  input logic                    trap_enter,
  input logic                    ctl_wr_cwp,
  input logic [NWIN-1:0]         ctl_wdata,
  input logic [$clog2(NWIN)-1:0] cwp_o,
  input logic [NWIN-1:0]         wim_o,
  input logic                    ovf_flag,
  input logic                    unf_flag
);
  localparam int CWPW = $clog2(NWIN);

  logic [CWPW-1:0] cwp_dn, cwp_up;
  assign cwp_dn = cwp_o - CWPW'(1);
  assign cwp_up = cwp_o + CWPW'(1);

  AST_ZERO_REG_A: assert property (@(posedge clk) disable iff (rst)
    (rd_a_addr == 5'd0) |=> (rd_a_data == '0)); // R2
  AST_ZERO_REG_B: assert property (@(posedge clk) disable iff (rst)
    (rd_b_addr == 5'd0) |=> (rd_b_data == '0)); // R2
  AST_SAVE_STEP: assert property (@(posedge clk) disable iff (rst)
    (save_req && !ctl_wr_cwp && !trap_enter && !wim_o[cwp_dn])
      |=> (cwp_o == $past(cwp_dn) && !ovf_flag)); // R7
  AST_RESTORE_STEP: assert property (@(posedge clk) disable iff (rst)
    (restore_req && !save_req && !ctl_wr_cwp && !trap_enter && !wim_o[cwp_up])
      |=> (cwp_o == $past(cwp_up) && !unf_flag)); // R7
  AST_OVF_HOLD: assert property (@(posedge clk) disable iff (rst)
    ovf_flag |-> (cwp_o == $past(cwp_o) && $past(save_req))); // R8
  AST_UNF_HOLD: assert property (@(posedge clk) disable iff (rst)
    unf_flag |-> (cwp_o == $past(cwp_o) && $past(restore_req))); // R8
  AST_FLAG_EXCL: assert property (@(posedge clk) disable iff (rst)
    !(ovf_flag && unf_flag)); // R8
  AST_TRAP_STEP: assert property (@(posedge clk) disable iff (rst)
    (trap_enter && !ctl_wr_cwp) |=> (cwp_o == $past(cwp_dn) && !ovf_flag && !unf_flag)); // R9
  AST_CWP_LOAD: assert property (@(posedge clk) disable iff (rst)
    ctl_wr_cwp |=> (cwp_o == $past(ctl_wdata[CWPW-1:0]))); // R10 R11
endmodule

bind winreg_file winreg_file_chk #(.NWIN(NWIN), .XLEN(XLEN)) u_chk (
  .clk(clk), .rst(rst),
  .rd_a_addr(rd_a_addr), .rd_b_addr(rd_b_addr),
  .rd_a_data(rd_a_data), .rd_b_data(rd_b_data),
  .save_req(save_req), .restore_req(restore_req), .trap_enter(trap_enter),
  .ctl_wr_cwp(ctl_wr_cwp), .ctl_wdata(ctl_wdata),
  .cwp_o(cwp_o), .wim_o(wim_o), .ovf_flag(ovf_flag), .unf_flag(unf_flag)
);

// File: tb/winreg_file_tb_top.sv
module winreg_file_tb_top;
  localparam int NW         = 8;
  localparam int XL         = 32;
  localparam int CLK_PERIOD = 10;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic [4:0]    rd_a_addr = '0, rd_b_addr = '0, wr_addr = '0;
  logic [XL-1:0] rd_a_data, rd_b_data, wr_data = '0;
  logic          wr_en = 1'b0, save_req = 1'b0, restore_req = 1'b0, trap_enter = 1'b0;
  logic          ctl_wr_cwp = 1'b0, ctl_wr_wim = 1'b0;
  logic [NW-1:0] ctl_wdata = '0;
  logic [2:0]    cwp_o;
  logic [NW-1:0] wim_o;
  logic          ovf_flag, unf_flag;

  int n_chk = 0;
  int n_err = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  winreg_file #(.NWIN(NW), .XLEN(XL)) dut_i (
    .clk(clk), .rst(rst),
    .rd_a_addr(rd_a_addr), .rd_b_addr(rd_b_addr),
    .rd_a_data(rd_a_data), .rd_b_data(rd_b_data),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .save_req(save_req), .restore_req(restore_req), .trap_enter(trap_enter),
    .ctl_wr_cwp(ctl_wr_cwp), .ctl_wr_wim(ctl_wr_wim), .ctl_wdata(ctl_wdata),
    .cwp_o(cwp_o), .wim_o(wim_o), .ovf_flag(ovf_flag), .unf_flag(unf_flag)
  );

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] vfun(input int w, input int r);
    return 32'hC0DE_0000 | (w << 8) | r;
  endfunction

  task automatic wr(input int a, input logic [31:0] d);
    wr_en = 1'b1; wr_addr = 5'(a); wr_data = d;
    tick();
    wr_en = 1'b0;
  endtask

  task automatic rd(input int a, input int b);
    rd_a_addr = 5'(a); rd_b_addr = 5'(b);
    tick();
  endtask

  task automatic set_cwp(input int v);
    ctl_wr_cwp = 1'b1; ctl_wdata = NW'(v);
    tick();
    ctl_wr_cwp = 1'b0;
  endtask

  task automatic set_wim(input logic [NW-1:0] v);
    ctl_wr_wim = 1'b1; ctl_wdata = v;
    tick();
    ctl_wr_wim = 1'b0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_err++;
    $display("FAIL watchdog: actual=hung expected=finished");
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    tick(); tick(); tick();
    // R1: state while reset is held
    chk("R1 cwp", 32'(cwp_o), 0);
    chk("R1 wim", 32'(wim_o), 0);
    chk("R1 flags", {30'd0, ovf_flag, unf_flag}, 0);
    chk("R1 rd_a", rd_a_data, 0);
    chk("R1 rd_b", rd_b_data, 0);
    rst = 1'b0;
    tick();
    chk("R1 cwp after release", 32'(cwp_o), 0);

    // Fill the outs and locals of every window
    for (int w = 0; w < NW; w++) begin
      set_cwp(w);
      for (int k = 0; k < 8; k++) begin
        wr(8 + k, vfun(w, 8 + k));
        wr(16 + k, vfun(w, 16 + k));
      end
    end
    // R5 locals are private; R6 ins alias the outs of the window above
    for (int w = 0; w < NW; w++) begin
      set_cwp(w);
      chk("R10 cwp load", 32'(cwp_o), w);
      for (int k = 0; k < 8; k++) begin
        rd(16 + k, 8 + k);
        chk("R5 local", rd_a_data, vfun(w, 16 + k));
        chk("R6 out", rd_b_data, vfun(w, 8 + k));
        rd(24 + k, 24 + k);
        chk("R6 in from window above", rd_a_data, vfun((w + 1) % NW, 8 + k));
        chk("R6 in port B", rd_b_data, vfun((w + 1) % NW, 8 + k));
      end
    end
    // R6 write through an in-register, read as the out of the upper window
    set_cwp(3);
    wr(26, 32'h1234_5678);
    set_cwp(4);
    rd(10, 0);
    chk("R6 in->out alias", rd_a_data, 32'h1234_5678);
    chk("R2 port B reg0", rd_b_data, 0);

    // R3 globals shared
    set_cwp(0);
    for (int g = 1; g < 8; g++) wr(g, 32'h6000_0000 + g);
    for (int w = 0; w < NW; w++) begin
      set_cwp(w);
      for (int g = 1; g < 8; g++) begin
        rd(g, 8 - g);
        chk("R3 global A", rd_a_data, 32'h6000_0000 + g);
        chk("R3 global B", rd_b_data, 32'h6000_0000 + (8 - g));
      end
    end

    // R2 reg 0 write discarded
    wr(0, 32'hFFFF_FFFF);
    rd(0, 0);
    chk("R2 reg0 A", rd_a_data, 0);
    chk("R2 reg0 B", rd_b_data, 0);
    rd(1, 16);
    chk("R2 globals untouched", rd_a_data, 32'h6000_0001);
    chk("R2 local untouched", rd_b_data, vfun(NW - 1, 16));

    // R4 read-before-write in the same cycle
    set_cwp(2);
    wr(17, 32'hAAAA_0001);
    rd_a_addr = 5'd17;
    wr_en = 1'b1; wr_addr = 5'd17; wr_data = 32'hBBBB_0002;
    tick();
    wr_en = 1'b0;
    chk("R4 old value same cycle", rd_a_data, 32'hAAAA_0001);
    tick();
    chk("R4 new value next cycle", rd_a_data, 32'hBBBB_0002);

    // R7 full ring of saves then restores
    set_wim('0);
    set_cwp(0);
    for (int i = 0; i < NW; i++) begin
      save_req = 1'b1; tick(); save_req = 1'b0;
      chk("R7 save step", 32'(cwp_o), (NW - 1 - i) % NW);
      chk("R7 no ovf", 32'(ovf_flag), 0);
    end
    for (int i = 0; i < NW; i++) begin
      restore_req = 1'b1; tick(); restore_req = 1'b0;
      chk("R7 restore step", 32'(cwp_o), (i + 1) % NW);
      chk("R7 no unf", 32'(unf_flag), 0);
    end

    // R8 refused saves and restores; R9 trap ignores mask
    for (int i = 0; i < NW; i++) begin
      set_wim(NW'(1) << i);
      chk("R10 wim load", 32'(wim_o), 1 << i);
      set_cwp((i + 1) % NW);
      save_req = 1'b1; tick(); save_req = 1'b0;
      chk("R8 ovf set", 32'(ovf_flag), 1);
      chk("R8 cwp held on ovf", 32'(cwp_o), (i + 1) % NW);
      tick();
      chk("R8 ovf one cycle", 32'(ovf_flag), 0);
      set_cwp((i + NW - 1) % NW);
      restore_req = 1'b1; tick(); restore_req = 1'b0;
      chk("R8 unf set", 32'(unf_flag), 1);
      chk("R8 ovf quiet on restore", 32'(ovf_flag), 0);
      chk("R8 cwp held on unf", 32'(cwp_o), (i + NW - 1) % NW);
      tick();
      chk("R8 unf one cycle", 32'(unf_flag), 0);
      set_cwp((i + 1) % NW);
      trap_enter = 1'b1; tick(); trap_enter = 1'b0;
      chk("R9 trap enters marked window", 32'(cwp_o), i);
      chk("R9 no flag", {30'd0, ovf_flag, unf_flag}, 0);
    end

    // R11 priority
    set_wim('0);
    set_cwp(3);
    ctl_wr_cwp = 1'b1; ctl_wdata = NW'(6); save_req = 1'b1; trap_enter = 1'b1;
    tick();
    ctl_wr_cwp = 1'b0; trap_enter = 1'b0;
    chk("R11 load wins", 32'(cwp_o), 6);
    trap_enter = 1'b1; restore_req = 1'b1;
    tick();
    trap_enter = 1'b0;
    chk("R11 trap wins single step", 32'(cwp_o), 5);
    tick();
    save_req = 1'b0; restore_req = 1'b0;
    chk("R11 save over restore", 32'(cwp_o), 4);
    set_wim(8'h08);
    save_req = 1'b1; restore_req = 1'b1;
    tick();
    save_req = 1'b0; restore_req = 1'b0;
    chk("R11 refused save blocks restore", 32'(cwp_o), 4);
    chk("R11 only ovf", {30'd0, ovf_flag, unf_flag}, 2);

    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule